// File: doc/BRIEF.md
# Mailbox Command Responder

This block is the controller-side engine of a request/reply protocol carried over a sixteen-byte mailbox. The host fills the request bytes through a byte-wide write port and rings a doorbell. The responder then latches the command and sequence bytes and decodes the arguments. It updates its record of the open flash window and of the dirty byte range. It writes the reply arguments, writes the sequence number back into its slot and stores a response code. Last, it pulses the host interrupt for one cycle.

Only one window is open at a time, either read or write. Marking data dirty is recorded locally and answered at once. Flushing hands a byte range to an external backing store over a request/done handshake, and no reply is given before that store reports completion. The controller status byte collects asynchronous event bits. A pulse input sets these bits and an acknowledge command clears them. Bit 0 comes out of reset set, to tell the host that all window and dirty state is gone.

Top module: `mbox_responder`

## Requirements
- R1: After reset, mailbox bytes 0 to 14 read 0x00, byte 15 reads 0x01 (bit 0 = controller restarted), no window is open, no range is dirty, and hostIrq and storeReq are low.
- R2: A host write to any byte other than 13 and 15 stores the data. A host write to byte 13 (response code) or byte 15 (controller status) leaves that byte unchanged.
- R3: Each reply rewrites byte 1 with the sequence number read at the doorbell and puts the response code in byte 13 (1 success, 2 parameter error, 3 write error). hostIrq then goes high for exactly one cycle. For a command that does not use the backing store, hostIrq is high in the second cycle after the cycle in which the doorbell was sampled.
- R4: Command 2 (mailbox info) replies with success and writes the following little-endian fields: API version in byte 2, read window size in blocks in bytes 3 to 4, write window size in blocks in bytes 5 to 6, and log2 of the block size in byte 7.
- R5: Command 3 (flash info) replies with success and writes two little-endian fields: flash size in bytes in bytes 2 to 5, and erase granule in bytes in bytes 6 to 9.
- R6: Commands 4 (open read window) and 6 (open write window) take a block offset, little-endian, in bytes 2 to 3. If the offset is at or beyond the flash size in blocks, the reply is parameter error. Otherwise the window opens, bytes 2 to 3 return the fixed host-side position, the reply is success, and the dirty record is dropped.
- R7: An open-window command that arrives while a window of the other kind is open returns parameter error and changes nothing. Opening the same kind again replaces the window. Command 5 closes the window, drops the dirty record and replies success.
- R8: Command 7 (mark dirty) takes a block index in bytes 2 to 3 and a byte count in bytes 4 to 7, both little-endian. It returns parameter error unless a write window is open. Otherwise it merges the range into one span, from the lowest start to the highest end, and replies success without raising storeReq.
- R9: Command 8 (flush) with a non-zero count raises storeReq with storeAddr = (window offset + index) × block size and storeLen = count. storeReq, storeAddr and storeLen hold until storeDone. No reply comes before storeDone. The code is 1 on success (the dirty record is cleared) or 3 when storeErr accompanies storeDone (the dirty record is kept). A flush returns parameter error unless a write window is open.
- R10: Command 8 with a zero count writes back the merged dirty span: storeAddr = window offset × block size + span start, and storeLen = span length. If nothing is dirty, it replies success at once with no store request.
- R11: Command 9 clears exactly the bits of byte 15 that are set in byte 2. The evtSet input sets bits of byte 15 one cycle later. When a set and a clear reach the same bit in the same cycle, the set wins.
- R12: Any command code outside 1 to 9 returns parameter error.
- R13: Command 1 (reset state) closes the window, drops the dirty record and replies success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hostWrEn | input | 1 | Host byte write strobe |
| hostAddr | input | 4 | Mailbox byte index for write and read |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Mailbox byte at hostAddr (combinational) |
| hostDoorbell | input | 1 | Request doorbell from the host |
| hostIrq | output | 1 | One-cycle reply interrupt to the host |
| evtSet | input | 8 | Event bits to set in controller status byte |
| storeReq | output | 1 | Backing-store write-back request |
| storeAddr | output | 32 | Flash byte address of write-back |
| storeLen | output | 32 | Byte count of write-back |
| storeDone | input | 1 | Backing store finished |
| storeErr | input | 1 | Backing store failed (valid with storeDone) |

## Verification
The event-set input and the acknowledge command both modify the controller status byte, and they can land on the same clock edge. The bench provokes this by driving evtSet in the cycle between the doorbell sample and the reply edge of an acknowledge. In that cycle the acknowledge bitmap clears a bit that evtSet is setting again. The bench judges the status byte read back afterwards against its own model, in which the set takes priority over the clear. Between collisions, the model also checks hostIrq and storeReq on every clock.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NBYTES = 16;
  localparam logic [7:0] CMD_RESET    = 8'd1;
  localparam logic [7:0] CMD_INFO     = 8'd2;
  localparam logic [7:0] CMD_FLASH    = 8'd3;
  localparam logic [7:0] CMD_OPEN_RD  = 8'd4;
  localparam logic [7:0] CMD_CLOSE    = 8'd5;
  localparam logic [7:0] CMD_OPEN_WR  = 8'd6;
  localparam logic [7:0] CMD_DIRTY    = 8'd7;
  localparam logic [7:0] CMD_FLUSH    = 8'd8;
  localparam logic [7:0] CMD_ACK      = 8'd9;
  localparam logic [7:0] RSP_OK       = 8'd1;
  localparam logic [7:0] RSP_PARAM    = 8'd2;
  localparam logic [7:0] RSP_WRERR    = 8'd3;
  localparam int BYTE_SEQ  = 1;
  localparam int BYTE_ARG  = 2;
  localparam int BYTE_CODE = 13;
  localparam int BYTE_STAT = 15;

  typedef enum logic [1:0] {WIN_NONE, WIN_RD, WIN_WR} win_t;

  typedef struct packed {
    logic capture;
    logic wrReply;
    logic startStore;
    logic finStore;
  } strobe_t;
endpackage

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
#(
  parameter logic [7:0]  API_VER     = 8'd1,
  parameter logic [15:0] RD_WIN_BLKS = 16'h0100,
  parameter logic [15:0] WR_WIN_BLKS = 16'h0080,
  parameter int          BLK_LOG2    = 12,
  parameter logic [31:0] FLASH_BYTES = 32'h0200_0000,
  parameter logic [31:0] ERASE_BYTES = 32'h0000_1000,
  parameter logic [15:0] WIN_POS     = 16'h0F00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  strobe_t     stb,
  input  logic        hostWrEn,
  input  logic [3:0]  hostAddr,
  input  logic [7:0]  hostWrData,
  output logic [7:0]  hostRdData,
  input  logic [7:0]  evtSet,
  input  logic        storeErr,
  output logic        needStore,
  output logic [31:0] storeAddr,
  output logic [31:0] storeLen,
  output logic [7:0]  statusByte,
  output logic [7:0]  codeByte
);
  localparam logic [31:0] FLASH_BLKS = FLASH_BYTES >> BLK_LOG2;

  logic [7:0]  mboxQ [NBYTES];
  logic [7:0]  cmdQ, seqQ;
  win_t        winKindQ, winKindN;
  logic [15:0] winOffQ, winOffN;
  logic        dirtyVQ;
  logic [31:0] dirtyLoQ, dirtyHiQ;
  logic [31:0] storeAddrQ, storeLenQ;

  logic [15:0] idx;
  logic [31:0] cnt, startB, endB, winBase, stAddrN, stLenN;
  logic [7:0]  rspCode, ackMask, repWe;
  logic [7:0]  rep [8];
  logic        winUpd, dirtyClr, dirtyMerge;
  win_t        otherKind;

  assign idx     = {mboxQ[3], mboxQ[2]};
  assign cnt     = {mboxQ[7], mboxQ[6], mboxQ[5], mboxQ[4]};
  assign startB  = 32'(idx) << BLK_LOG2;
  assign endB    = startB + cnt;
  assign winBase = 32'(winOffQ) << BLK_LOG2;

  always_comb begin
    rspCode    = RSP_PARAM;
    repWe      = '0;
    rep        = '{default: 8'h00};
    winUpd     = 1'b0;
    winKindN   = winKindQ;
    winOffN    = winOffQ;
    dirtyClr   = 1'b0;
    dirtyMerge = 1'b0;
    needStore  = 1'b0;
    ackMask    = '0;
    stAddrN    = winBase + startB;
    stLenN     = cnt;
    otherKind  = (cmdQ == CMD_OPEN_RD) ? WIN_WR : WIN_RD;
    case (cmdQ)
      CMD_RESET, CMD_CLOSE: begin
        rspCode  = RSP_OK;
        winUpd   = 1'b1;
        winKindN = WIN_NONE;
        dirtyClr = 1'b1;
      end
      CMD_INFO: begin
        rspCode = RSP_OK;
        repWe   = 8'h3F;
        rep[0]  = API_VER;
        rep[1]  = RD_WIN_BLKS[7:0];
        rep[2]  = RD_WIN_BLKS[15:8];
        rep[3]  = WR_WIN_BLKS[7:0];
        rep[4]  = WR_WIN_BLKS[15:8];
        rep[5]  = 8'(BLK_LOG2);
      end
      CMD_FLASH: begin
        rspCode = RSP_OK;
        repWe   = 8'hFF;
        for (int i = 0; i < 4; i++) begin
          rep[i]   = FLASH_BYTES[8*i +: 8];
          rep[i+4] = ERASE_BYTES[8*i +: 8];
        end
      end
      CMD_OPEN_RD, CMD_OPEN_WR: begin
        if (winKindQ != otherKind && 32'(idx) < FLASH_BLKS) begin
          rspCode  = RSP_OK;
          winUpd   = 1'b1;
          winKindN = (cmdQ == CMD_OPEN_RD) ? WIN_RD : WIN_WR;
          winOffN  = idx;
          dirtyClr = 1'b1;
          repWe    = 8'h03;
          rep[0]   = WIN_POS[7:0];
          rep[1]   = WIN_POS[15:8];
        end
      end
      CMD_DIRTY: begin
        if (winKindQ == WIN_WR) begin
          rspCode    = RSP_OK;
          dirtyMerge = 1'b1;
        end
      end
      CMD_FLUSH: begin
        if (winKindQ == WIN_WR) begin
          if (cnt != '0) begin
            needStore = 1'b1;
          end else if (dirtyVQ) begin
            needStore = 1'b1;
            stAddrN   = winBase + dirtyLoQ;
            stLenN    = dirtyHiQ - dirtyLoQ;
          end else begin
            rspCode = RSP_OK;
          end
        end
      end
      CMD_ACK: begin
        rspCode = RSP_OK;
        ackMask = mboxQ[BYTE_ARG];
      end
      default: rspCode = RSP_PARAM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) mboxQ[i] <= 8'h00;
      mboxQ[BYTE_STAT] <= 8'h01;
      cmdQ       <= '0;
      seqQ       <= '0;
      winKindQ   <= WIN_NONE;
      winOffQ    <= '0;
      dirtyVQ    <= 1'b0;
      dirtyLoQ   <= '0;
      dirtyHiQ   <= '0;
      storeAddrQ <= '0;
      storeLenQ  <= '0;
    end else begin
      if (hostWrEn && hostAddr != 4'(BYTE_CODE) && hostAddr != 4'(BYTE_STAT))
        mboxQ[hostAddr] <= hostWrData;
      if (stb.capture) begin
        cmdQ <= mboxQ[0];
        seqQ <= mboxQ[BYTE_SEQ];
      end
      if (stb.wrReply) begin
        mboxQ[BYTE_SEQ]  <= seqQ;
        mboxQ[BYTE_CODE] <= rspCode;
        for (int i = 0; i < 8; i++)
          if (repWe[i]) mboxQ[BYTE_ARG+i] <= rep[i];
        if (winUpd) begin
          winKindQ <= winKindN;
          winOffQ  <= winOffN;
        end
        if (dirtyClr) begin
          dirtyVQ <= 1'b0;
        end else if (dirtyMerge) begin
          dirtyVQ  <= 1'b1;
          dirtyLoQ <= (!dirtyVQ || startB < dirtyLoQ) ? startB : dirtyLoQ;
          dirtyHiQ <= (!dirtyVQ || endB > dirtyHiQ) ? endB : dirtyHiQ;
        end
      end
      if (stb.startStore) begin
        storeAddrQ <= stAddrN;
        storeLenQ  <= stLenN;
      end
      if (stb.finStore) begin
        mboxQ[BYTE_SEQ]  <= seqQ;
        mboxQ[BYTE_CODE] <= storeErr ? RSP_WRERR : RSP_OK;
        if (!storeErr) dirtyVQ <= 1'b0;
      end
      mboxQ[BYTE_STAT] <= (mboxQ[BYTE_STAT] & ~(stb.wrReply ? ackMask : 8'h00)) | evtSet;
    end
  end

  assign hostRdData = mboxQ[hostAddr];
  assign storeAddr  = storeAddrQ;
  assign storeLen   = storeLenQ;
  assign statusByte = mboxQ[BYTE_STAT];
  assign codeByte   = mboxQ[BYTE_CODE];
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hostDoorbell,
  input  logic    needStore,
  input  logic    storeDone,
  output strobe_t stb,
  output logic    hostIrq,
  output logic    storeReq
);
  typedef enum logic [1:0] {S_IDLE, S_DEC, S_STORE, S_RESP} state_t;
  state_t stateQ, stateN;

  always_comb begin
    stateN = stateQ;
    stb    = '0;
    case (stateQ)
      S_IDLE: if (hostDoorbell) begin
        stb.capture = 1'b1;
        stateN      = S_DEC;
      end
      S_DEC: begin
        if (needStore) begin
          stb.startStore = 1'b1;
          stateN         = S_STORE;
        end else begin
          stb.wrReply = 1'b1;
          stateN      = S_RESP;
        end
      end
      S_STORE: if (storeDone) begin
        stb.finStore = 1'b1;
        stateN       = S_RESP;
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= S_IDLE;
    else        stateQ <= stateN;
  end

  assign hostIrq  = (stateQ == S_RESP);
  assign storeReq = (stateQ == S_STORE);
endmodule

// File: rtl/mbox_responder.sv
module mbox_responder
  import mbox_pkg::*;
#(
  parameter logic [7:0]  API_VER     = 8'd1,
  parameter logic [15:0] RD_WIN_BLKS = 16'h0100,
  parameter logic [15:0] WR_WIN_BLKS = 16'h0080,
  parameter int          BLK_LOG2    = 12,
  parameter logic [31:0] FLASH_BYTES = 32'h0200_0000,
  parameter logic [31:0] ERASE_BYTES = 32'h0000_1000,
  parameter logic [15:0] WIN_POS     = 16'h0F00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hostWrEn,
  input  logic [3:0]  hostAddr,
  input  logic [7:0]  hostWrData,
  output logic [7:0]  hostRdData,
  input  logic        hostDoorbell,
  output logic        hostIrq,
  input  logic [7:0]  evtSet,
  output logic        storeReq,
  output logic [31:0] storeAddr,
  output logic [31:0] storeLen,
  input  logic        storeDone,
  input  logic        storeErr
);
  strobe_t    stb;
  logic       needStore;
  logic [7:0] statusByte, codeByte;

  mbox_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .hostDoorbell(hostDoorbell),
    .needStore(needStore), .storeDone(storeDone),
    .stb(stb), .hostIrq(hostIrq), .storeReq(storeReq)
  );

  mbox_dp #(
    .API_VER(API_VER), .RD_WIN_BLKS(RD_WIN_BLKS), .WR_WIN_BLKS(WR_WIN_BLKS),
    .BLK_LOG2(BLK_LOG2), .FLASH_BYTES(FLASH_BYTES), .ERASE_BYTES(ERASE_BYTES),
    .WIN_POS(WIN_POS)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .evtSet(evtSet), .storeErr(storeErr),
    .needStore(needStore), .storeAddr(storeAddr), .storeLen(storeLen),
    .statusByte(statusByte), .codeByte(codeByte)
  );
endmodule

// File: rtl/mbox_responder_chk.sv
module mbox_responder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hostIrq,
  input logic        storeReq,
  input logic        storeDone,
  input logic [31:0] storeAddr,
  input logic [31:0] storeLen,
  input logic [7:0]  evtSet,
  input logic [7:0]  statusByte,
  input logic [7:0]  codeByte
);
  // R3
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hostIrq |=> !hostIrq);

  // R3
  code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hostIrq |-> (codeByte >= 8'd1 && codeByte <= 8'd3));

  // R9
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (storeReq && !storeDone) |=> (storeReq && $stable(storeAddr) && $stable(storeLen)));

  // R9
  no_early_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    storeReq |-> !hostIrq);

  // R11
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evtSet) |=> ((statusByte & $past(evtSet)) == $past(evtSet)));
endmodule

bind mbox_responder mbox_responder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .hostIrq(hostIrq), .storeReq(storeReq),
  .storeDone(storeDone), .storeAddr(storeAddr), .storeLen(storeLen),
  .evtSet(evtSet), .statusByte(statusByte), .codeByte(codeByte)
);

// File: tb/mbox_responder_tb_top.sv
`timescale 1ns/1ps
module mbox_responder_tb_top;
  localparam longint BLK = 4096;
  localparam longint FLASH_BLKS = 32'h0200_0000 / BLK;

  logic        clk = 0, rst_n = 0;
  logic        hostWrEn = 0, hostDoorbell = 0, storeDone = 0, storeErr = 0;
  logic [3:0]  hostAddr = 0;
  logic [7:0]  hostWrData = 0, evtSet = 0;
  logic [7:0]  hostRdData;
  logic        hostIrq, storeReq;
  logic [31:0] storeAddr, storeLen;

  int errs = 0, checks = 0;
  logic expIrq = 0, expStoreReq = 0, monOn = 0;

  // behavioural model state
  int     mWin = 0;
  longint mOff = 0, mLo = 0, mHi = 0;
  bit     mDv = 0;
  logic [7:0] mStat = 8'h01;

  mbox_responder dut_i (
    .clk(clk), .rst_n(rst_n), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .hostDoorbell(hostDoorbell),
    .hostIrq(hostIrq), .evtSet(evtSet), .storeReq(storeReq), .storeAddr(storeAddr),
    .storeLen(storeLen), .storeDone(storeDone), .storeErr(storeErr)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (monOn) begin
    chk("R3 hostIrq per-cycle", {31'd0, hostIrq}, {31'd0, expIrq});
    chk("R9 storeReq per-cycle", {31'd0, storeReq}, {31'd0, expStoreReq});
  end

  task automatic hwr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1; hostAddr = a; hostWrData = d;
    @(posedge clk);
  endtask

  task automatic rdB(input logic [3:0] a, output logic [7:0] v);
    hostAddr = a; #1; v = hostRdData;
  endtask

  task automatic postEvt(input logic [7:0] v);
    @(negedge clk); evtSet = v;
    @(negedge clk); evtSet = 0;
    mStat = mStat | v;
  endtask

  task automatic runCmd(input string tag, input logic [7:0] cmd, input logic [7:0] seq,
                        input logic [15:0] idx, input logic [31:0] cnt,
                        input bit inj, input logic [7:0] evtDur);
    logic [7:0] code, v;
    bit st;
    longint eA, eL, s, e;
    int other;
    code = 2; st = 0; eA = 0; eL = 0;
    case (cmd)
      1, 5: begin code = 1; mWin = 0; mDv = 0; end
      2, 3: code = 1;
      4, 6: begin
        other = (cmd == 4) ? 2 : 1;
        if (mWin != other && idx < FLASH_BLKS) begin
          code = 1; mWin = (cmd == 4) ? 1 : 2; mOff = idx; mDv = 0;
        end
      end
      7: if (mWin == 2) begin
        code = 1; s = idx * BLK; e = s + cnt;
        if (!mDv || s < mLo) mLo = s;
        if (!mDv || e > mHi) mHi = e;
        mDv = 1;
      end
      8: if (mWin == 2) begin
        if (cnt != 0) begin st = 1; eA = (mOff + idx) * BLK; eL = cnt; end
        else if (mDv) begin st = 1; eA = mOff * BLK + mLo; eL = mHi - mLo; end
        else code = 1;
        if (st) begin code = inj ? 3 : 1; if (!inj) mDv = 0; end
      end
      9: code = 1;
      default: code = 2;
    endcase
    if (cmd == 9) mStat = (mStat & ~idx[7:0]) | evtDur;
    else mStat = mStat | evtDur;

    hwr(0, cmd); hwr(1, seq);
    hwr(2, idx[7:0]); hwr(3, idx[15:8]);
    for (int i = 0; i < 4; i++) hwr(4'(4 + i), cnt[8*i +: 8]);
    @(negedge clk); hostWrEn = 0; hostDoorbell = 1;
    @(posedge clk);
    @(negedge clk); hostDoorbell = 0; evtSet = evtDur;
    @(posedge clk);
    if (!st) begin
      expIrq = 1;
      @(negedge clk); evtSet = 0;
      @(posedge clk); expIrq = 0;
      @(negedge clk);
    end else begin
      expStoreReq = 1;
      @(negedge clk); evtSet = 0;
      chk({tag, " storeAddr"}, storeAddr, 32'(eA));
      chk({tag, " storeLen"}, storeLen, 32'(eL));
      repeat (3) @(negedge clk);
      storeErr = inj; storeDone = 1;
      @(posedge clk); expStoreReq = 0; expIrq = 1;
      @(negedge clk); storeDone = 0; storeErr = 0;
      @(posedge clk); expIrq = 0;
      @(negedge clk);
    end
    rdB(1, v);  chk({tag, " R3 seq echo"}, {24'd0, v}, {24'd0, seq});
    rdB(13, v); chk({tag, " code"}, {24'd0, v}, {24'd0, code});
    rdB(15, v); chk({tag, " R11 status"}, {24'd0, v}, {24'd0, mStat});
  endtask

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    monOn = 1;
    // R1 reset state
    for (int i = 0; i < 16; i++) begin
      rdB(4'(i), v);
      chk("R1 reset byte", {24'd0, v}, (i == 15) ? 32'h01 : 32'h00);
    end
    // R2 protected bytes
    hwr(13, 8'h5A); hwr(15, 8'hA5); hwr(14, 8'h3C);
    @(negedge clk); hostWrEn = 0;
    rdB(13, v); chk("R2 byte13 ignored", {24'd0, v}, 32'h00);
    rdB(15, v); chk("R2 byte15 ignored", {24'd0, v}, 32'h01);
    rdB(14, v); chk("R2 byte14 stored", {24'd0, v}, 32'h3C);
    // R4 mailbox info
    runCmd("R4", 8'd2, 8'h11, 16'h0, 32'h0, 0, 8'h00);
    rdB(2, v); chk("R4 api", {24'd0, v}, 32'h01);
    rdB(3, v); chk("R4 rd lo", {24'd0, v}, 32'h00);
    rdB(4, v); chk("R4 rd hi", {24'd0, v}, 32'h01);
    rdB(5, v); chk("R4 wr lo", {24'd0, v}, 32'h80);
    rdB(6, v); chk("R4 wr hi", {24'd0, v}, 32'h00);
    rdB(7, v); chk("R4 blk log2", {24'd0, v}, 32'd12);
    // R5 flash info
    runCmd("R5", 8'd3, 8'h22, 16'h0, 32'h0, 0, 8'h00);
    rdB(5, v); chk("R5 flash b3", {24'd0, v}, 32'h02);
    rdB(4, v); chk("R5 flash b2", {24'd0, v}, 32'h00);
    rdB(7, v); chk("R5 erase b1", {24'd0, v}, 32'h10);
    rdB(9, v); chk("R5 erase b3", {24'd0, v}, 32'h00);
    // R12 unknown codes
    runCmd("R12 code0", 8'd0, 8'h33, 16'h0, 32'h0, 0, 8'h00);
    runCmd("R12 code12", 8'd12, 8'h34, 16'h0, 32'h0, 0, 8'h00);
    // R8 no window
    runCmd("R8 nowin", 8'd7, 8'h35, 16'h1, 32'h10, 0, 8'h00);
    // R6 out of range and open read
    runCmd("R6 range", 8'd4, 8'h36, 16'h2000, 32'h0, 0, 8'h00);
    runCmd("R6 open rd", 8'd4, 8'h37, 16'h0005, 32'h0, 0, 8'h00);
    rdB(2, v); chk("R6 pos lo", {24'd0, v}, 32'h00);
    rdB(3, v); chk("R6 pos hi", {24'd0, v}, 32'h0F);
    // R7 conflict, close, reopen
    runCmd("R7 conflict", 8'd6, 8'h38, 16'h0010, 32'h0, 0, 8'h00);
    runCmd("R7 close", 8'd5, 8'h39, 16'h0, 32'h0, 0, 8'h00);
    runCmd("R7 open wr", 8'd6, 8'h3A, 16'h0010, 32'h0, 0, 8'h00);
    // R8 merge two ranges
    runCmd("R8 dirty a", 8'd7, 8'h40, 16'h0002, 32'h100, 0, 8'h00);
    runCmd("R8 dirty b", 8'd7, 8'h41, 16'h0001, 32'h80, 0, 8'h00);
    // R10 zero-count flush of merged span, then nothing dirty
    runCmd("R10 flush span", 8'd8, 8'h42, 16'h0, 32'h0, 0, 8'h00);
    runCmd("R10 flush empty", 8'd8, 8'h43, 16'h0, 32'h0, 0, 8'h00);
    // R9 explicit flush with error, then success
    runCmd("R9 flush err", 8'd8, 8'h44, 16'h0003, 32'h40, 1, 8'h00);
    runCmd("R9 flush ok", 8'd8, 8'h45, 16'h0004, 32'h20, 0, 8'h00);
    // R11 events and acknowledge
    postEvt(8'h0A);
    rdB(15, v); chk("R11 evt set", {24'd0, v}, {24'd0, mStat});
    runCmd("R11 ack", 8'd9, 8'h50, 16'h0003, 32'h0, 0, 8'h00);
    runCmd("R11 collide", 8'd9, 8'h51, 16'h000C, 32'h0, 0, 8'h04);
    // R13 reset-state command
    runCmd("R13 reset", 8'd1, 8'h60, 16'h0, 32'h0, 0, 8'h00);
    runCmd("R13 after", 8'd7, 8'h61, 16'h0, 32'h10, 0, 8'h00);
    repeat (2) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 4);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule